// File: doc/BRIEF.md
# Binary32 Floating-Point Multiplier

This block multiplies two IEEE-754 single-precision operands and returns the correctly rounded product together with four exception flags: invalid, overflow, underflow and inexact. Operands may be normal, subnormal, zero, infinite or NaN. Products that fall below the normal range are rounded directly into the subnormal range, or to zero, under the selected rounding mode.

A caller presents both operands and a rounding mode and pulses `start` for one cycle. One clock later `done` pulses, and the product and flags appear on the outputs. They stay there until the next `start`. The parameter `LEGACY_NAN` selects between two NaN conventions:
- Standard style: NaNs are quieted and the invalid flag is raised.
- Legacy style: NaNs pass through unchanged and no flag is ever raised.

Top module: `fp32_mul`

## Requirements
- R1: While reset is asserted (`rst_n` low), `done` is 0, `prod` is 0 and all four flags are 0.
- R2: A `start` pulse sampled at a rising edge makes `done` high for exactly the following cycle. `prod` and the flags update only after a cycle with `start` high and otherwise hold their values.
- R3: For finite nonzero operands whose product lies in the normal range, `prod` is the exact product rounded under `rnd`. The encodings are 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity. `f_inx` is set exactly when the rounded value differs from the exact one. Example: 0x3f800001 times itself gives 0x3f800002 in modes 0, 1 and 3, and 0x3f800003 in mode 2.
- R4: When the rounded magnitude would exceed 0x7f7fffff, the result is signed infinity or the signed largest finite value, and `f_ovf` and `f_inx` are both set. Infinity is returned in mode 0, in mode 2 for a positive result and in mode 3 for a negative result. Example: 0x7f000000 times itself gives 0x7f800000 in modes 0 and 2 and 0x7f7fffff in modes 1 and 3.
- R5: Subnormal operands are accepted, and an exact product below 2^-126 is rounded at the 2^-149 quantum and may round up to the smallest normal value. `f_unf` is set exactly when the exact product is below 2^-126 and inexact, and then `f_inx` is set too. Example: 0x00800001 times 0x00800000 gives 0x00000000 in modes 0, 1 and 3 and 0x00000001 in mode 2.
- R6: The sign bit (bit 31) of every non-NaN result is the XOR of the operand signs. A zero operand times a finite operand gives a zero of that sign with no flags.
- R7: Infinity times a finite nonzero value gives an infinity of the XOR sign with no flags. Infinity times zero gives 0x7fc00000 and, in the standard style, sets `f_inv`.
- R8: In the standard style (`LEGACY_NAN`=0), a NaN operand makes the result operand B if B is NaN, otherwise operand A. The result has its quiet bit (bit 22) set. `f_inv` is set exactly when at least one operand is a signalling NaN, meaning exponent all ones, nonzero fraction and bit 22 clear.
- R9: In the legacy style (`LEGACY_NAN`=1), a NaN operand makes the result operand A if A is NaN, otherwise operand B, copied without change. All four flags stay 0 for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a multiply with the present operands and mode |
| op_a | input | 32 | Operand A, binary32 |
| op_b | input | 32 | Operand B, binary32 |
| rnd | input | 2 | Rounding mode (0 nearest-even, 1 zero, 2 +inf, 3 -inf) |
| done | output | 1 | One-cycle pulse marking a new result |
| prod | output | 32 | Rounded product, binary32 |
| f_inv | output | 1 | Invalid-operation flag |
| f_ovf | output | 1 | Overflow flag |
| f_unf | output | 1 | Underflow flag |
| f_inx | output | 1 | Inexact flag |

## Verification
A wrong leading-zero count or exponent sum shows in the very next result. It appears as a product off by a power of two or with a shifted fraction, and operand sets that mix subnormal and normal inputs expose it. A rounding-increment error changes only the last fraction bit or the carry into the exponent, so it appears only in the mode and sticky pattern that trigger it. For that reason every operand pair is run under all four modes and checked one cycle after `start`. Flag errors, such as underflow without inexact or overflow with the wrong saturation value, are visible in the same output word as the result.

// File: rtl/fp32_mul.sv
module fp32_mul #(
  parameter bit LEGACY_NAN = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic [1:0]  rnd,
  output logic        done,
  output logic [31:0] prod,
  output logic        f_inv,
  output logic        f_ovf,
  output logic        f_unf,
  output logic        f_inx
);
  localparam int MW = 24;
  localparam int PW = 2 * MW;
  localparam logic [31:0] DEF_NAN = 32'h7fc00000;

  logic sa, sb, sr;
  logic [7:0] ea, eb, ea_e, eb_e;
  logic [22:0] fa, fb;
  assign {sa, ea, fa} = op_a;
  assign {sb, eb, fb} = op_b;
  assign sr = sa ^ sb;
  assign ea_e = (ea == 8'd0) ? 8'd1 : ea;
  assign eb_e = (eb == 8'd0) ? 8'd1 : eb;

  logic a_nan, b_nan, a_snan, b_snan, a_inf, b_inf, a_zero, b_zero, inf_zero;
  assign a_nan  = (&ea) & (|fa);
  assign b_nan  = (&eb) & (|fb);
  assign a_snan = a_nan & ~fa[22];
  assign b_snan = b_nan & ~fb[22];
  assign a_inf  = (&ea) & ~(|fa);
  assign b_inf  = (&eb) & ~(|fb);
  assign a_zero = ~(|ea) & ~(|fa);
  assign b_zero = ~(|eb) & ~(|fb);
  assign inf_zero = (a_inf & b_zero) | (a_zero & b_inf);

  logic [PW-1:0] p, mn, mr;
  assign p = PW'({|ea, fa}) * PW'({|eb, fb});

  logic [5:0] lz;
  always_comb begin
    lz = '0;
    for (int i = 0; i < PW; i++)
      if (p[i]) lz = 6'(PW - 1 - i);
  end

  logic signed [10:0] xe, shr_full;
  logic tiny, huge, lost;
  logic [5:0] shc;
  assign xe = $signed({3'b0, ea_e}) + $signed({3'b0, eb_e}) - 11'sd126 - $signed({5'b0, lz});
  assign tiny = xe < 11'sd1;
  assign huge = xe > 11'sd254;
  assign shr_full = 11'sd1 - xe;
  assign shc = !tiny ? 6'd0 : (shr_full > 11'sd48) ? 6'd48 : shr_full[5:0];

  assign mn = p << lz;
  assign mr = mn >> shc;
  assign lost = |(mn & ((PW'(1) << shc) - PW'(1)));

  logic [MW-1:0] kept;
  logic rb, st, inc;
  assign kept = mr[PW-1:MW];
  assign rb = mr[MW-1];
  assign st = (|mr[MW-2:0]) | lost;

  always_comb begin
    case (rnd)
      2'd0:    inc = rb & (st | kept[0]);
      2'd1:    inc = 1'b0;
      2'd2:    inc = ~sr & (rb | st);
      default: inc = sr & (rb | st);
    endcase
  end

  logic [30:0] sum;
  logic ovf_c, inx_c, to_inf;
  assign sum = {(tiny ? 8'd0 : xe[7:0]), kept[22:0]} + 31'(inc);
  assign ovf_c = ~tiny & (huge | (&sum[30:23]));
  assign inx_c = rb | st | ovf_c;
  assign to_inf = (rnd == 2'd0) | ((rnd == 2'd2) & ~sr) | ((rnd == 2'd3) & sr);

  logic [31:0] res;
  logic iv, ov, un, ix;
  always_comb begin
    iv = 1'b0; ov = 1'b0; un = 1'b0; ix = 1'b0;
    if (a_nan | b_nan) begin
      if (LEGACY_NAN) res = a_nan ? op_a : op_b;
      else begin
        res = (b_nan ? op_b : op_a) | 32'h00400000;
        iv  = a_snan | b_snan;
      end
    end else if (inf_zero) begin
      res = DEF_NAN;
      iv  = 1'b1;
    end else if (a_inf | b_inf) res = {sr, 8'hff, 23'd0};
    else if (a_zero | b_zero) res = {sr, 31'd0};
    else if (ovf_c) begin
      res = to_inf ? {sr, 8'hff, 23'd0} : {sr, 8'hfe, 23'h7fffff};
      ov = 1'b1; ix = 1'b1;
    end else begin
      res = {sr, sum};
      ix = inx_c;
      un = tiny & inx_c;
    end
    if (LEGACY_NAN) {iv, ov, un, ix} = 4'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0;
      prod <= '0;
      {f_inv, f_ovf, f_unf, f_inx} <= 4'b0;
    end else begin
      done <= start;
      if (start) begin
        prod <= res;
        {f_inv, f_ovf, f_unf, f_inx} <= {iv, ov, un, ix};
      end
    end
  end

  // R5
  unf_implies_inx_chk: assert property (@(posedge clk) disable iff (!rst_n) f_unf |-> f_inx);
  // R4
  ovf_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_ovf |-> (f_inx && prod[30:23] >= 8'hfe));
  // R8
  inv_gives_qnan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_inv |-> (prod[30:23] == 8'hff && prod[22]));
  // R9
  legacy_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    LEGACY_NAN |-> !(f_inv || f_ovf || f_unf || f_inx));
  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!done && $stable(prod)));
  // R6
  sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !a_nan && !b_nan && !inf_zero) |=> prod[31] == $past(op_a[31] ^ op_b[31]));
endmodule

// File: tb/fp32_mul_test.sv
module fp32_mul_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [1:0] rnd = '0;
  logic done, done_l;
  logic [31:0] prod, prod_l;
  logic f_inv, f_ovf, f_unf, f_inx, l_inv, l_ovf, l_unf, l_inx;
  int errors = 0, checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fp32_mul #(.LEGACY_NAN(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b), .rnd(rnd),
    .done(done), .prod(prod), .f_inv(f_inv), .f_ovf(f_ovf), .f_unf(f_unf), .f_inx(f_inx));
  fp32_mul #(.LEGACY_NAN(1'b1)) uut_leg (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b), .rnd(rnd),
    .done(done_l), .prod(prod_l), .f_inv(l_inv), .f_ovf(l_ovf), .f_unf(l_unf), .f_inx(l_inx));

  function automatic logic [31:0] pick(int i);
    case (i)
      0: return 32'h00000000;  1: return 32'h80000000;  2: return 32'h00000001;
      3: return 32'h007fffff;  4: return 32'h00800000;  5: return 32'h00800001;
      6: return 32'h3f800000;  7: return 32'h3f800001;  8: return 32'h3fc00000;
      9: return 32'hbf800003; 10: return 32'h7f000000; 11: return 32'h7f7fffff;
      12: return 32'h00400000; 13: return 32'h34400000; 14: return 32'h7f800000;
      15: return 32'hff800000; 16: return 32'h7fc00001; 17: return 32'h7f800001;
      18: return 32'hffbfffff; 19: return 32'h3effffff; 20: return 32'h20000000;
      21: return 32'h5f000001; 22: return 32'h3f000000; 23: return 32'h00000003;
      default: return 32'hc0400000;
    endcase
  endfunction

  // returns {inv, ovf, unf, inx, result}
  function automatic logic [35:0] model(logic [31:0] a, logic [31:0] b, int m, bit leg);
    bit s = a[31] ^ b[31];
    bit an = (a[30:23] == 8'hff) && (a[22:0] != 0);
    bit bn = (b[30:23] == 8'hff) && (b[22:0] != 0);
    bit ai = (a[30:23] == 8'hff) && (a[22:0] == 0);
    bit bi = (b[30:23] == 8'hff) && (b[22:0] == 0);
    bit az = (a[30:0] == 0);
    bit bz = (b[30:0] == 0);
    logic [31:0] r;
    logic [3:0] f = 4'b0;
    longint ma, mb, pp, kept, rem, half, enc;
    int ea, eb, pe, n, e, q, sh;
    bit up, ov;
    if (an || bn) begin
      if (leg) r = an ? a : b;
      else begin
        r = (bn ? b : a) | 32'h00400000;
        f[3] = (an && !a[22]) || (bn && !b[22]);
      end
    end else if ((ai && bz) || (az && bi)) begin
      r = 32'h7fc00000; f[3] = 1'b1;
    end else if (ai || bi) r = {s, 8'hff, 23'd0};
    else if (az || bz) r = {s, 31'd0};
    else begin
      ma = longint'({(a[30:23] != 0), a[22:0]});
      mb = longint'({(b[30:23] != 0), b[22:0]});
      ea = (a[30:23] == 0) ? 1 : int'(a[30:23]);
      eb = (b[30:23] == 0) ? 1 : int'(b[30:23]);
      pp = ma * mb;
      pe = ea + eb - 300;
      n = 0;
      for (int k = 0; k < 48; k++) if (pp[k]) n = k;
      e = n + pe;
      q = (e >= -126) ? e - 23 : -149;
      sh = q - pe;
      half = 0;
      if (sh <= 0) begin kept = pp << (-sh); rem = 0; end
      else if (sh >= 62) begin kept = 0; rem = pp; half = 64'h4000000000000000; end
      else begin
        kept = pp >> sh;
        rem = pp & ((64'd1 << sh) - 1);
        half = 64'd1 << (sh - 1);
      end
      case (m)
        0: up = (rem > half) || (rem == half && rem != 0 && kept[0]);
        1: up = 1'b0;
        2: up = (rem != 0) && !s;
        default: up = (rem != 0) && s;
      endcase
      kept = kept + (up ? 1 : 0);
      enc = (longint'(q + 149) <<< 23) + kept;
      ov = enc >= 64'h7f800000;
      if (ov) begin
        if (m == 0 || (m == 2 && !s) || (m == 3 && s)) r = {s, 8'hff, 23'd0};
        else r = {s, 8'hfe, 23'h7fffff};
        f[2] = 1'b1; f[0] = 1'b1;
      end else begin
        r = {s, enc[30:0]};
        f[0] = (rem != 0);
        f[1] = (e < -126) && (rem != 0);
      end
    end
    if (leg) f = 4'b0;
    return {f, r};
  endfunction

  function automatic string tagof(logic [31:0] a, logic [31:0] b, logic [35:0] x, bit leg);
    bit nan = (&a[30:23] && |a[22:0]) || (&b[30:23] && |b[22:0]);
    if (leg) return "R9";
    if (nan) return "R8";
    if (&a[30:23] || &b[30:23]) return "R7";
    if (a[30:0] == 0 || b[30:0] == 0) return "R6";
    if (x[34]) return "R4";
    if (x[33] || x[30:23] == 0 || a[30:23] == 0 || b[30:23] == 0) return "R5";
    return "R3";
  endfunction

  task automatic check(string tag, logic [35:0] got, logic [35:0] exp,
                       logic [31:0] a, logic [31:0] b, int m);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h rnd=%0d got flags=%b res=%h expected flags=%b res=%h",
               tag, a, b, m, got[35:32], got[31:0], exp[35:32], exp[31:0]);
    end
  endtask

  task automatic run(logic [31:0] a, logic [31:0] b, int m);
    logic [35:0] e0, e1;
    @(negedge clk);
    op_a = a; op_b = b; rnd = 2'(m); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    e0 = model(a, b, m, 1'b0);
    e1 = model(a, b, m, 1'b1);
    check("R2", {35'd0, done & done_l}, 36'd1, a, b, m);
    check(tagof(a, b, e0, 1'b0), {f_inv, f_ovf, f_unf, f_inx, prod}, e0, a, b, m);
    check(tagof(a, b, e1, 1'b1), {l_inv, l_ovf, l_unf, l_inx, prod_l}, e1, a, b, m);
  endtask

  task automatic idle_check();
    logic [31:0] held;
    held = prod;
    op_a = 32'h40000000; op_b = 32'h40400000;
    @(negedge clk);
    // R2: no start, so done low and product held
    check("R2", {35'd0, done}, 36'd0, op_a, op_b, 0);
    check("R2", {4'd0, prod}, {4'd0, held}, op_a, op_b, 0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] x, ra, rb2;
    int eb;
    x = 32'h1234abcd;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1", {done, f_inv, f_ovf, f_unf, f_inx, prod[30:0]}, 36'd0, 0, 0, 0);
    check("R1", {3'd0, prod[31], done_l, l_inv, l_ovf, l_unf, l_inx, prod_l[26:0]}, 36'd0, 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R3/R4/R5/R7 stated corner points (all modes)
    for (int m = 0; m < 4; m++) begin
      run(32'h3f800001, 32'h3f800001, m);
      run(32'h7f000000, 32'h7f000000, m);
      run(32'h00800001, 32'h00800000, m);
      run(32'h7f800000, 32'h00000000, m);
    end
    idle_check();
    for (int i = 0; i < 25; i++)
      for (int j = 0; j < 25; j++)
        for (int m = 0; m < 4; m++)
          run(pick(i), pick(j), m);
    idle_check();
    for (int k = 0; k < 6000; k++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5); ra = x;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5); rb2 = x;
      if (k % 3 == 1) begin
        eb = 254 - int'(ra[30:23]) + int'(rb2[2:0]) + 124;
        eb = (eb < 0) ? 0 : (eb > 254) ? 254 : eb;
        rb2[30:23] = 8'(eb);
      end else if (k % 3 == 2) begin
        eb = 127 - int'(ra[30:23]) + int'(rb2[4:0]) - 25;
        eb = (eb < 0) ? 0 : (eb > 254) ? 254 : eb;
        rb2[30:23] = 8'(eb);
      end
      run(ra, rb2, k % 4);
    end
    idle_check();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule